// File: doc/BRIEF.md
# Length-Driven String Reversal Buffer

This block takes a stream of characters in which every string arrives last character first. A separate stream of string lengths marks where each string ends, and the block hands every string back in its natural order. Incoming characters go to consecutive slots of a circular dual-port character store. A length is pushed only once all characters of its string have been written. The lengths wait in a small FIFO.

A reader state machine turns the lengths into output. It has two states. In `RD_FETCH` it takes one length from the FIFO. In `RD_EMIT` it reads that string from its highest slot down to its base slot and then moves the base forward by the length. The transitions are:
- LOAD: `RD_FETCH` to `RD_EMIT`, when a non-zero length is taken.
- DROP: stays in `RD_FETCH`, when a zero length is taken; this raises the error flag.
- NEXT: stays in `RD_EMIT`, when a beat is accepted and characters remain.
- DONE: `RD_EMIT` to `RD_FETCH`, when the last character of the string is accepted.

Writing and reading use separate ports of the store, so they proceed in the same cycle. Characters leave through a valid/ready interface. No string may be empty or longer than the store depth.

Top module: `rsb_string_buf`

## Requirements
- R1: After reset `out_valid` and `len_err` are 0, and `in_ready` and `len_ready` are 1.
- R2: The characters of one string come out in the reverse of their write order: the last character written comes out first.
- R3: Strings come out in the order their lengths were pushed. Each uses exactly `len_value` consecutive characters of the write stream, with no character skipped or repeated.
- R4: With `out_ready` held at 1 and the next length already queued, a string of length L takes L+1 cycles. This gives exactly one cycle with `out_valid` low between consecutive strings.
- R5: Characters whose length has not yet been pushed are never output: `out_valid` stays 0 while the length FIFO is empty.
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_char` unchanged.
- R7: Store addresses wrap modulo `DEPTH`, so a stream longer than `DEPTH` characters in total is reproduced correctly.
- R8: `in_ready` is 0 exactly when `DEPTH` unread characters are stored. The characters of the string being emitted count as unread until its last character is accepted. A character offered while `in_ready` is 0 is not stored.
- R9: `len_ready` is 0 when the length FIFO holds `LDEPTH` entries. Lengths remain usable after space returns.
- R10: A length of 0 sets `len_err`, which then stays 1 until reset. That length is discarded and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A character is offered |
| in_ready | output | 1 | Store has room for a character |
| in_char | input | DW | Character, strings arriving last character first |
| len_valid | input | 1 | A string length is offered |
| len_ready | output | 1 | Length FIFO has room |
| len_value | input | $clog2(DEPTH)+1 | Length of a completely written string, 1 to DEPTH |
| out_valid | output | 1 | An output character is presented |
| out_ready | input | 1 | Downstream accepts the character |
| out_char | output | DW | Character in natural string order |
| len_err | output | 1 | Sticky flag: a zero length was seen |

## Verification
The bench builds the block with a 16-slot character store and a 4-entry length FIFO. With these sizes a few dozen short strings wrap the store addresses several times. A single 16-character string fills the store, and five one-character strings fill the length FIFO while the reader is stalled. The output side runs with ready held high, held low and toggling in a repeating pattern. This exercises the one-cycle gap between strings, the holding of stalled data, and writes that keep arriving while reads are in progress.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
    typedef enum logic [0:0] {
        RD_FETCH = 1'b0,
        RD_EMIT  = 1'b1
    } rd_state_e;
endpackage

// File: rtl/rsb_len_fifo.sv
module rsb_len_fifo #(
    parameter int LW     = 5,
    parameter int LDEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [LW-1:0] push_data,
    input  logic          pop,
    output logic          not_full,
    output logic          not_empty,
    output logic [LW-1:0] head
);
    localparam int LAW = (LDEPTH > 1) ? $clog2(LDEPTH) : 1;

    logic [LW-1:0] slots [LDEPTH];
    logic [LAW:0]  wp;
    logic [LAW:0]  rp;
    logic [LAW:0]  fill;

    assign fill      = wp - rp;
    assign not_full  = (fill != (LAW+1)'(LDEPTH));
    assign not_empty = (fill != '0);
    assign head      = slots[rp[LAW-1:0]];

    always_ff @(posedge clk) begin
        if (push) slots[wp[LAW-1:0]] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= (LAW+1)'(LDEPTH));

    // R3
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> fill != '0);
endmodule

// File: rtl/rsb_char_ram.sv
module rsb_char_ram #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int SLOTS = 1 << AW;

    logic [DW-1:0] mem [SLOTS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/rsb_reader.sv
module rsb_reader
    import rsb_pkg::*;
#(
    parameter int AW = 4,
    parameter int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          len_avail,
    input  logic [LW-1:0] len_head,
    output logic          len_pop,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   base_ptr,
    output logic          err
);
    rd_state_e     state, state_n;
    logic [AW:0]   base, base_n;
    logic [LW-1:0] cur_len, cur_len_n;
    logic [LW-1:0] remain, remain_n;
    logic [AW-1:0] rd_ptr, rd_ptr_n;
    logic          err_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= RD_FETCH;
            base    <= '0;
            cur_len <= '0;
            remain  <= '0;
            rd_ptr  <= '0;
            err     <= 1'b0;
        end else begin
            state   <= state_n;
            base    <= base_n;
            cur_len <= cur_len_n;
            remain  <= remain_n;
            rd_ptr  <= rd_ptr_n;
            err     <= err_n;
        end
    end

    always_comb begin
        state_n   = state;
        base_n    = base;
        cur_len_n = cur_len;
        remain_n  = remain;
        rd_ptr_n  = rd_ptr;
        err_n     = err;
        unique case (state)
            RD_FETCH: begin
                if (len_avail) begin
                    if (len_head == '0) begin
                        err_n = 1'b1;
                    end else begin
                        state_n   = RD_EMIT;
                        cur_len_n = len_head;
                        remain_n  = len_head;
                        rd_ptr_n  = base[AW-1:0] + len_head[AW-1:0] - 1'b1;
                    end
                end
            end
            RD_EMIT: begin
                if (out_ready) begin
                    if (remain == LW'(1)) begin
                        state_n = RD_FETCH;
                        base_n  = base + cur_len;
                    end else begin
                        remain_n = remain - 1'b1;
                        rd_ptr_n = rd_ptr - 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        out_valid = (state == RD_EMIT);
        len_pop   = (state == RD_FETCH) && len_avail;
        rd_addr   = rd_ptr_n;
        base_ptr  = base;
    end

    // R3
    emit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == RD_EMIT |-> remain != '0);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/rsb_string_buf.sv
module rsb_string_buf #(
    parameter int DW     = 8,
    parameter int DEPTH  = 16,
    parameter int LDEPTH = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_char,
    input  logic          len_valid,
    output logic          len_ready,
    input  logic [LW-1:0] len_value,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_char,
    output logic          len_err
);
    logic [AW:0]   wptr;
    logic [AW:0]   base_ptr;
    logic [AW:0]   occ;
    logic [AW-1:0] rd_addr;
    logic          wr_fire;
    logic          len_avail;
    logic          len_pop;
    logic [LW-1:0] len_head;

    assign occ      = wptr - base_ptr;
    assign in_ready = (occ != LW'(DEPTH));
    assign wr_fire  = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wptr <= '0;
        else if (wr_fire) wptr <= wptr + 1'b1;
    end

    rsb_char_ram #(.DW(DW), .AW(AW)) ram_i (
        .clk     (clk),
        .wr_en   (wr_fire),
        .wr_addr (wptr[AW-1:0]),
        .wr_data (in_char),
        .rd_addr (rd_addr),
        .rd_data (out_char)
    );

    rsb_len_fifo #(.LW(LW), .LDEPTH(LDEPTH)) lfifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (len_valid && len_ready),
        .push_data (len_value),
        .pop       (len_pop),
        .not_full  (len_ready),
        .not_empty (len_avail),
        .head      (len_head)
    );

    rsb_reader #(.AW(AW), .LW(LW)) reader_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_avail (len_avail),
        .len_head  (len_head),
        .len_pop   (len_pop),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .rd_addr   (rd_addr),
        .base_ptr  (base_ptr),
        .err       (len_err)
    );

    // R8
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= LW'(DEPTH));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_char));
endmodule

// File: tb/rsb_string_buf_tb.sv
module rsb_string_buf_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW     = 8;
    localparam int DEPTH  = 16;
    localparam int LDEPTH = 4;
    localparam int LW     = $clog2(DEPTH) + 1;
    localparam int WD_CYCLES = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_char = '0;
    logic          len_valid = 1'b0;
    logic          len_ready;
    logic [LW-1:0] len_value = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_char;
    logic          len_err;

    int            n_checks = 0;
    int            n_fails = 0;
    int            cyc = 0;
    int            ready_mode = 0;
    string         tag = "R1";
    logic [DW-1:0] exp_q [$];
    int            beat_cyc [$];
    bit            log_beats = 1'b0;
    bit            prev_stall = 1'b0;
    logic [DW-1:0] prev_char = '0;
    bit            finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsb_string_buf #(.DW(DW), .DEPTH(DEPTH), .LDEPTH(LDEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_char(in_char),
        .len_valid(len_valid), .len_ready(len_ready), .len_value(len_value),
        .out_valid(out_valid), .out_ready(out_ready), .out_char(out_char),
        .len_err(len_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // scoreboard monitor: owns out_ready, compares accepted beats
    always begin
        @(negedge clk);
        cyc++;
        case (ready_mode)
            0:       out_ready = 1'b0;
            1:       out_ready = 1'b1;
            default: out_ready = (cyc % 3) != 0;
        endcase
        #1;
        if (rst_n) begin
            if (prev_stall) begin
                // R6 stalled beat stays presented and unchanged
                check(out_valid && out_char == prev_char, "R6", int'(out_char), int'(prev_char));
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, tag, int'(out_char), -1);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(out_char == e, tag, int'(out_char), int'(e));
                end
                if (log_beats) beat_cyc.push_back(cyc);
            end
            prev_stall = out_valid && !out_ready;
            prev_char  = out_char;
        end
    end

    task automatic put_char(input logic [DW-1:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_char  = d;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic put_len(input int l);
        @(negedge clk);
        len_valid = 1'b1;
        len_value = LW'(l);
        #1;
        while (!len_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        len_valid = 1'b0;
    endtask

    // chars written start..start+len-1; natural order is the reverse
    task automatic send_string(input int len, input logic [DW-1:0] start);
        for (int k = 0; k < len; k++) put_char(start + DW'(k));
        for (int k = len - 1; k >= 0; k--) exp_q.push_back(start + DW'(k));
        put_len(len);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset values
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(len_err == 1'b0, "R1", int'(len_err), 0);
        check(in_ready == 1'b1, "R1", int'(in_ready), 1);
        check(len_ready == 1'b1, "R1", int'(len_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 single string reversed
        tag = "R2";
        ready_mode = 1;
        send_string(5, 8'h10);
        drain();

        // R5 no output before the length arrives
        tag = "R5";
        for (int k = 0; k < 3; k++) put_char(8'h30 + DW'(k));
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            #2;
            check(out_valid == 1'b0, "R5", int'(out_valid), 0);
        end
        for (int k = 2; k >= 0; k--) exp_q.push_back(8'h30 + DW'(k));
        put_len(3);
        drain();

        // R4 L+1 cycles per string
        tag = "R4";
        ready_mode = 0;
        send_string(3, 8'h40);
        send_string(4, 8'h50);
        repeat (3) @(negedge clk);
        beat_cyc.delete();
        log_beats = 1'b1;
        ready_mode = 1;
        drain();
        log_beats = 1'b0;
        check(beat_cyc.size() == 7, "R4", beat_cyc.size(), 7);
        if (beat_cyc.size() == 7) begin
            check(beat_cyc[6] - beat_cyc[0] == 7, "R4", beat_cyc[6] - beat_cyc[0], 7);
            check(beat_cyc[3] - beat_cyc[2] == 2, "R4", beat_cyc[3] - beat_cyc[2], 2);
        end

        // R6 toggling ready
        tag = "R6";
        ready_mode = 2;
        send_string(2, 8'h60);
        send_string(7, 8'h68);
        send_string(1, 8'h70);
        send_string(5, 8'h78);
        drain();

        // R3 growing lengths back to back
        tag = "R3";
        ready_mode = 1;
        for (int i = 1; i <= 6; i++) send_string(i, DW'(8'h80 + 8 * i));
        drain();

        // R7 long stream wrapping the store, concurrent traffic
        tag = "R7";
        for (int i = 0; i < 24; i++) begin
            ready_mode = (i % 2 == 0) ? 2 : 1;
            send_string((i % 8) + 1, DW'(i * 11));
        end
        drain();
        ready_mode = 1;

        // R8 full store gates writes
        tag = "R8";
        ready_mode = 0;
        for (int k = 0; k < DEPTH; k++) put_char(8'hA0 + DW'(k));
        @(negedge clk);
        #1;
        check(in_ready == 1'b0, "R8", int'(in_ready), 0);
        in_valid = 1'b1;
        in_char  = 8'hEE;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            #1;
            check(in_ready == 1'b0, "R8", int'(in_ready), 0);
        end
        in_valid = 1'b0;
        for (int k = DEPTH - 1; k >= 0; k--) exp_q.push_back(8'hA0 + DW'(k));
        put_len(DEPTH);
        repeat (4) @(negedge clk);
        #1;
        check(in_ready == 1'b0, "R8", int'(in_ready), 0);
        ready_mode = 1;
        drain();
        #1;
        check(in_ready == 1'b1, "R8", int'(in_ready), 1);

        // R9 full length FIFO
        tag = "R9";
        ready_mode = 0;
        send_string(1, 8'hC0);
        repeat (3) @(negedge clk);
        for (int i = 1; i <= LDEPTH; i++) send_string(1, 8'hC0 + DW'(i));
        @(negedge clk);
        #1;
        check(len_ready == 1'b0, "R9", int'(len_ready), 0);
        ready_mode = 1;
        drain();
        #1;
        check(len_ready == 1'b1, "R9", int'(len_ready), 1);

        // R10 zero length flagged and discarded
        tag = "R10";
        put_len(0);
        repeat (4) @(negedge clk);
        #2;
        check(len_err == 1'b1, "R10", int'(len_err), 1);
        check(out_valid == 1'b0, "R10", int'(out_valid), 0);
        send_string(2, 8'hD0);
        drain();
        #1;
        check(len_err == 1'b1, "R10", int'(len_err), 1);
        check(exp_q.size() == 0, "R3", exp_q.size(), 0);

        summary();
    end
endmodule